// File: doc/BRIEF.md
# Processor Address Region Decoder with Address-Loaded Control Register

This block sorts every 26-bit processor address into one of eight regions. The read map and the write map differ. The eight regions are logically mapped RAM, physically mapped RAM, the I/O controllers, low ROM, high ROM, the video controller, the memory controller's own control space, and the page translator. Region selection uses the five top address bits, so the granularity is 2 MB. Decoding is purely combinational from the address and the read/write strobe. Alongside the region code the block gives the RAM and ROM word indexes, which are the address masked to the installed sizes.

The block holds a control register that is loaded only from address lines. A qualified write into the control space takes its operating-system mode, sound and video DMA enables, refresh mode, two ROM access times and page size from fixed address bit positions. No data bus is involved.

After reset, a ROM overlay makes reads in the logically mapped RAM region report high ROM. The first real read into the high-ROM region clears the overlay until the next reset. A few interrupt status reads in the I/O region return fixed values.

Top module: `mmap_decoder`

## Requirements
- R1: For reads, `region` is decoded from addr[25:21]. The region codes are:
  - 0: addr < 0x2000000 (logical RAM).
  - 1: 0x2000000–0x2FFFFFF (physical RAM).
  - 2: 0x3000000–0x33FFFFF (I/O).
  - 3: 0x3400000–0x37FFFFF (low ROM).
  - 4: addr >= 0x3800000 (high ROM).
- R2: For writes (`accWrite`=1), the lower three ranges decode as for reads. The upper ranges decode as follows:
  - 5: 0x3400000–0x35FFFFF (video controller).
  - 6: 0x3600000–0x37FFFFF (control space).
  - 7: addr >= 0x3800000 (translator).
- R3: A valid write in region 6 with addr[19:17]=111 loads the control register at the next clock edge. The fields are:
  - `osMode` = addr[12].
  - `soundDmaEn` = addr[11].
  - `videoDmaEn` = addr[10].
  - `hiRomTime` = addr[7:6].
  - `loRomTime` = addr[5:4].
  - `pageSize` = addr[3:2].
  - Both time fields use 00=450 ns, 01=325 ns, 10=200 ns, 11=200 ns with nibble mode. `pageSize` uses 00=4 KB, 01=8 KB, 10=16 KB, 11=32 KB.
- R4: On a load, `refreshMode` becomes 01 (refresh during flyback) when addr[9:8]=01 and 11 (continuous refresh) when addr[9:8]=11. Any other value gives 00 (no refresh), so `refreshMode` never holds 10.
- R5: The control register keeps its value for any access that does not qualify under R3. This covers a write in region 6 with addr[19:17]≠111, a read at a load address, and any cycle with `accValid`=0.
- R6: After reset all control fields are 0 and `overlayOn`=1.
- R7: While `overlayOn`=1, a read with addr < 0x2000000 reports region 4. A write to the same range still reports region 0.
- R8: A valid read with addr >= 0x3800000 clears `overlayOn` at the next clock edge, and it stays clear until reset. An overlaid read below 0x2000000 does not clear it.
- R9: A valid read in region 2 returns `statusData` according to addr[6:0]:
  - 0x10 or 0x30: 0x80.
  - 0x20: 0x00.
  - Anything else, or any access that is not a valid read in region 2: 0x00.
- R10: `ramIndex` = addr[RAM_IDX_W-1:0] and `romIndex` = addr[ROM_IDX_W-1:0]. The defaults are 20 and 21 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access qualifies this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 26 | Processor byte address |
| region | output | 3 | Region code (R1, R2, R7) |
| ramIndex | output | RAM_IDX_W | Masked RAM index |
| romIndex | output | ROM_IDX_W | Masked ROM index |
| statusData | output | 8 | Interrupt status read value |
| overlayOn | output | 1 | Reset ROM overlay active |
| osMode | output | 1 | Operating-system mode bit |
| soundDmaEn | output | 1 | Sound DMA enable |
| videoDmaEn | output | 1 | Video DMA enable |
| refreshMode | output | 2 | 00 none, 01 flyback, 11 continuous |
| hiRomTime | output | 2 | High-ROM access time code |
| loRomTime | output | 2 | Low-ROM access time code |
| pageSize | output | 2 | Page size code |

## Verification
The assertions assume that `accWrite` and `accAddr` are stable and known whenever `accValid` is high. They also assume that reset is applied before the first qualified access. The bench changes inputs only on falling edges, holds each access for exactly one rising edge, and drives the region-table sweep with `accValid` low so that it cannot disturb the overlay or the control register. The R8 sequence then relies on the bench making no high-ROM read before the overlay checks.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [2:0] {
    RG_LOG_RAM  = 3'd0,
    RG_PHYS_RAM = 3'd1,
    RG_IO       = 3'd2,
    RG_LO_ROM   = 3'd3,
    RG_HI_ROM   = 3'd4,
    RG_VIDEO    = 3'd5,
    RG_CTL      = 3'd6,
    RG_XLATE    = 3'd7
  } region_e;

  typedef struct packed {
    logic       osMode;
    logic       soundDmaEn;
    logic       videoDmaEn;
    logic [1:0] refreshMode;
    logic [1:0] hiRomTime;
    logic [1:0] loRomTime;
    logic [1:0] pageSize;
  } ctl_reg_t;

  // 0 none, 1 status A, 2 status B, 3 fast-interrupt status
  typedef struct packed {
    logic       loadCtl;
    logic       clearOverlay;
    logic [1:0] statusSel;
  } strobes_t;
endpackage

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              overlayOn,
  output region_e           region,
  output strobes_t          strobes
);
  localparam int SEL_W = 5;
  localparam int SEL_LSB = ADDR_W - SEL_W;

  logic [SEL_W-1:0] sel;
  region_e baseRegion;

  assign sel = accAddr[ADDR_W-1:SEL_LSB];

  always_comb begin
    if (!sel[4])                baseRegion = RG_LOG_RAM;
    else if (sel[4:3] == 2'b10) baseRegion = RG_PHYS_RAM;
    else if (sel[4:1] == 4'b1100) baseRegion = RG_IO;
    else if (sel == 5'b11010)   baseRegion = accWrite ? RG_VIDEO : RG_LO_ROM;
    else if (sel == 5'b11011)   baseRegion = accWrite ? RG_CTL : RG_LO_ROM;
    else                        baseRegion = accWrite ? RG_XLATE : RG_HI_ROM;
  end

  always_comb begin
    region = baseRegion;
    if (overlayOn && !accWrite && baseRegion == RG_LOG_RAM) region = RG_HI_ROM;
  end

  always_comb begin
    strobes = '0;
    strobes.loadCtl = accValid && accWrite && baseRegion == RG_CTL
                      && accAddr[19:17] == 3'b111;
    strobes.clearOverlay = accValid && !accWrite && baseRegion == RG_HI_ROM;
    if (accValid && !accWrite && baseRegion == RG_IO) begin
      case (accAddr[6:0])
        7'h10:   strobes.statusSel = 2'd1;
        7'h20:   strobes.statusSel = 2'd2;
        7'h30:   strobes.statusSel = 2'd3;
        default: strobes.statusSel = 2'd0;
      endcase
    end
  end

  // R2
  write_no_rom_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWrite |-> (region != RG_LO_ROM && region != RG_HI_ROM));
  // R1
  read_no_wronly_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accWrite |-> (region != RG_VIDEO && region != RG_CTL && region != RG_XLATE));
  // R3
  load_is_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCtl |-> (accWrite && accValid && region == RG_CTL));
endmodule

// File: rtl/mmap_datapath.sv
module mmap_datapath
  import mmap_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int RAM_IDX_W = 20,
  parameter int ROM_IDX_W = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    accAddr,
  input  strobes_t             strobes,
  output ctl_reg_t             ctlReg,
  output logic                 overlayOn,
  output logic [7:0]           statusData,
  output logic [RAM_IDX_W-1:0] ramIndex,
  output logic [ROM_IDX_W-1:0] romIndex
);
  ctl_reg_t ctlNext;

  always_comb begin
    ctlNext.osMode      = accAddr[12];
    ctlNext.soundDmaEn  = accAddr[11];
    ctlNext.videoDmaEn  = accAddr[10];
    ctlNext.refreshMode = accAddr[8] ? {accAddr[9], 1'b1} : 2'b00;
    ctlNext.hiRomTime   = accAddr[7:6];
    ctlNext.loRomTime   = accAddr[5:4];
    ctlNext.pageSize    = accAddr[3:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg    <= '0;
      overlayOn <= 1'b1;
    end else begin
      if (strobes.loadCtl) ctlReg <= ctlNext;
      if (strobes.clearOverlay) overlayOn <= 1'b0;
    end
  end

  always_comb begin
    case (strobes.statusSel)
      2'd1, 2'd3: statusData = 8'h80;
      default:    statusData = 8'h00;
    endcase
  end

  assign ramIndex = accAddr[RAM_IDX_W-1:0];
  assign romIndex = accAddr[ROM_IDX_W-1:0];

  // R3
  load_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCtl |=> (ctlReg.osMode == $past(accAddr[12])
                         && ctlReg.pageSize == $past(accAddr[3:2])
                         && ctlReg.hiRomTime == $past(accAddr[7:6])));
  // R5
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCtl |=> $stable(ctlReg));
  // R4
  refresh_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg.refreshMode != 2'b10);
  // R8
  overlay_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !overlayOn |=> !overlayOn);
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int RAM_IDX_W = 20,
  parameter int ROM_IDX_W = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic [2:0]           region,
  output logic [RAM_IDX_W-1:0] ramIndex,
  output logic [ROM_IDX_W-1:0] romIndex,
  output logic [7:0]           statusData,
  output logic                 overlayOn,
  output logic                 osMode,
  output logic                 soundDmaEn,
  output logic                 videoDmaEn,
  output logic [1:0]           refreshMode,
  output logic [1:0]           hiRomTime,
  output logic [1:0]           loRomTime,
  output logic [1:0]           pageSize
);
  region_e  regionE;
  strobes_t strobes;
  ctl_reg_t ctlReg;

  mmap_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .overlayOn(overlayOn), .region(regionE), .strobes(strobes)
  );

  mmap_datapath #(.ADDR_W(ADDR_W), .RAM_IDX_W(RAM_IDX_W), .ROM_IDX_W(ROM_IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .strobes(strobes), .ctlReg(ctlReg),
    .overlayOn(overlayOn), .statusData(statusData), .ramIndex(ramIndex),
    .romIndex(romIndex)
  );

  assign region      = regionE;
  assign osMode      = ctlReg.osMode;
  assign soundDmaEn  = ctlReg.soundDmaEn;
  assign videoDmaEn  = ctlReg.videoDmaEn;
  assign refreshMode = ctlReg.refreshMode;
  assign hiRomTime   = ctlReg.hiRomTime;
  assign loRomTime   = ctlReg.loRomTime;
  assign pageSize    = ctlReg.pageSize;
endmodule

// File: tb/test_mmap_decoder.sv
module test_mmap_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic accWrite = 1'b0;
  logic [25:0] accAddr = '0;
  logic [2:0] region;
  logic [19:0] ramIndex;
  logic [20:0] romIndex;
  logic [7:0] statusData;
  logic overlayOn, osMode, soundDmaEn, videoDmaEn;
  logic [1:0] refreshMode, hiRomTime, loRomTime, pageSize;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmap_decoder i_mmap_decoder (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .region(region), .ramIndex(ramIndex), .romIndex(romIndex), .statusData(statusData),
    .overlayOn(overlayOn), .osMode(osMode), .soundDmaEn(soundDmaEn),
    .videoDmaEn(videoDmaEn), .refreshMode(refreshMode), .hiRomTime(hiRomTime),
    .loRomTime(loRomTime), .pageSize(pageSize)
  );

  // {write, addr[25:0], expected region}
  localparam logic [29:0] VEC [18] = '{
    {1'b0, 26'h0000000, 3'd0}, {1'b0, 26'h1FFFFFF, 3'd0},
    {1'b0, 26'h2000000, 3'd1}, {1'b0, 26'h2FFFFFF, 3'd1},
    {1'b0, 26'h3000000, 3'd2}, {1'b0, 26'h33FFFFF, 3'd2},
    {1'b0, 26'h3400000, 3'd3}, {1'b0, 26'h37FFFFF, 3'd3},
    {1'b0, 26'h3800000, 3'd4}, {1'b0, 26'h3FFFFFF, 3'd4},
    {1'b1, 26'h1FFFFFF, 3'd0}, {1'b1, 26'h2000000, 3'd1},
    {1'b1, 26'h33FFFFF, 3'd2}, {1'b1, 26'h3400000, 3'd5},
    {1'b1, 26'h35FFFFF, 3'd5}, {1'b1, 26'h3600000, 3'd6},
    {1'b1, 26'h37FFFFF, 3'd6}, {1'b1, 26'h3800000, 3'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [25:0] a);
    @(negedge clk);
    accValid = 1'b1; accWrite = w; accAddr = a;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  function automatic logic [10:0] ctlWord();
    return {osMode, soundDmaEn, videoDmaEn, refreshMode, hiRomTime, loRomTime, pageSize};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 ctl", 32'(ctlWord()), 32'h0);
    check("R6 overlay", 32'(overlayOn), 32'h1);
    // R7 overlay read vs write
    accWrite = 1'b0; accAddr = 26'h0012345; #1;
    check("R7 read", 32'(region), 32'd4);
    check("R10 rom idx overlay", 32'(romIndex), 32'h12345);
    accWrite = 1'b1; #1;
    check("R7 write", 32'(region), 32'd0);
    // R8 overlaid read does not clear
    access(1'b0, 26'h0000100);
    check("R8 overlaid read keeps", 32'(overlayOn), 32'h1);
    access(1'b0, 26'h3800000);
    check("R8 cleared", 32'(overlayOn), 32'h0);
    accWrite = 1'b0; accAddr = 26'h0000100; #1;
    check("R8 logical after clear", 32'(region), 32'd0);
    access(1'b1, 26'h3600000);
    check("R8 sticky", 32'(overlayOn), 32'h0);

    // R1 / R2 table sweep with accValid low
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      accWrite = VEC[i][29]; accAddr = VEC[i][28:3]; #1;
      check(VEC[i][29] ? "R2 write map" : "R1 read map", 32'(region), 32'(VEC[i][2:0]));
    end

    // R3 / R4 control loads
    access(1'b1, 26'h36E179C);
    check("R3 load fields", 32'(ctlWord()), {21'h0, 1'b1, 1'b0, 1'b1, 2'b11, 2'b10, 2'b01, 2'b11});
    // R5 no load: bit17 clear, read, invalid
    access(1'b1, 26'h36C0A00);
    check("R5 bad select", 32'(ctlWord()), {21'h0, 11'b101_11_10_01_11});
    access(1'b0, 26'h36E0A00);
    check("R5 read", 32'(ctlWord()), {21'h0, 11'b101_11_10_01_11});
    @(negedge clk); accWrite = 1'b1; accAddr = 26'h36E0A00;
    @(negedge clk);
    check("R5 invalid", 32'(ctlWord()), {21'h0, 11'b101_11_10_01_11});
    access(1'b1, 26'h36E0A00);
    check("R4 refresh 10->00", 32'(ctlWord()), {21'h0, 11'b010_00_00_00_00});
    access(1'b1, 26'h36E0100);
    check("R4 refresh flyback", 32'(refreshMode), 32'h1);

    // R9 status reads
    @(negedge clk); accValid = 1'b1; accWrite = 1'b0; accAddr = 26'h3000010; #1;
    check("R9 status A", 32'(statusData), 32'h80);
    accAddr = 26'h3000020; #1;
    check("R9 status B", 32'(statusData), 32'h00);
    accAddr = 26'h3200030; #1;
    check("R9 fiq", 32'(statusData), 32'h80);
    accAddr = 26'h3000040; #1;
    check("R9 other", 32'(statusData), 32'h00);
    accWrite = 1'b1; accAddr = 26'h3000010; #1;
    check("R9 write", 32'(statusData), 32'h00);
    accValid = 1'b0; accWrite = 1'b0; #1;
    check("R9 invalid", 32'(statusData), 32'h00);

    // R10 index masking
    accAddr = 26'h2ABCDEF; #1;
    check("R10 ram idx", 32'(ramIndex), 32'hBCDEF);
    accAddr = 26'h3FFFFFF; #1;
    check("R10 rom idx", 32'(romIndex), 32'h1FFFFF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule